// File: doc/BRIEF.md
# Synthesizer Serial Register Loader

This block programs an integer-N frequency synthesizer over a three-wire serial link made up of a serial clock, a serial data line and a latch strobe. Every register write is a 24-bit word. The block pulls the strobe low, shifts the word out most-significant bit first, and raises the strobe again once the last bit has been clocked. The data line changes only while the serial clock is low. The receiver samples it on each rising serial clock edge.

After reset the block runs a fixed start-up sequence of three writes: the reference divider word, then the feedback divider word, then the initialization word. Their payloads are parameters, and the block appends the two-bit register address itself. Host writes wait until this sequence has finished. After that a host hands over one complete 24-bit word at a time through a ready/valid pair and receives a one-cycle done pulse when the word is latched.

The block also registers a chip-enable request onto the power-down control pin, separately from the serial lines. It synchronises the synthesizer's lock-detect line and reports it as a lock flag.

Top module: `synth_prog_ctrl`

## Requirements
- R1: While reset is held, the latch strobe is high, the serial clock and serial data are low, and req_ready, xfer_done, init_done and locked are all low.
- R2: After reset the block sends exactly three words, in this order: {REF_PAYLOAD, 2'b00}, {FB_PAYLOAD, 2'b01} and {INIT_PAYLOAD, 2'b11}. The register address occupies bits [1:0] of each 24-bit word.
- R3: req_ready stays low until the third start-up word has been latched. init_done rises in the same cycle as that word's xfer_done pulse and stays high until the next reset.
- R4: Each word is framed by the latch strobe. The strobe falls before the first rising serial clock edge. There are exactly 24 rising serial clock edges while it is low. It rises only after the last of them. The serial clock is low whenever the strobe is high.
- R5: Bits leave most-significant first. Serial data is stable for as long as the serial clock is high, so a receiver that samples on the rising edge recovers the word exactly.
- R6: Each serial clock half period lasts CLK_DIV system cycles. The latch strobe stays low for 49*CLK_DIV cycles per word. The one-cycle xfer_done pulse appears together with the strobe's rising edge, 49*CLK_DIV cycles after the edge that accepted the word.
- R7: A host word is accepted only on a cycle where both req_valid and req_ready are high, and it is sent unchanged. While a transfer is in progress, req_ready is low and req_valid and req_word have no effect.
- R8: chip_en takes the value of chip_en_req one cycle later, whether or not a transfer is in progress.
- R9: locked shows lock_in through a two-stage synchroniser and an output register, so it follows lock_in three cycles later. It is held low until init_done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host offers a word |
| req_word | input | WORD_W | Host word, sent unchanged |
| req_ready | output | 1 | Block can accept a host word this cycle |
| xfer_done | output | 1 | One-cycle pulse when a word is latched |
| init_done | output | 1 | Start-up sequence complete |
| chip_en_req | input | 1 | Host power-up request |
| chip_en | output | 1 | Registered chip-enable to the synthesizer |
| lock_in | input | 1 | Lock-detect line from the synthesizer |
| locked | output | 1 | Synchronised lock status |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch strobe, low during a word |

## Verification
The bench takes as the reference point the falling-edge sample in which req_valid and req_ready are both high. It expects xfer_done in the sample 49*CLK_DIV+1 cycles later and counts falling edges to confirm that spacing. chip_en is checked one cycle after the request changes, in the middle of a transfer. locked is checked two cycles after a lock_in change, where it must still hold the old value, and again at three cycles, where it must show the new one. A behavioural receiver shifts data on rising serial clock edges and files each word on the strobe's rising edge, so word contents are compared in the sample where xfer_done is seen.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_COMMIT = 2'd3
    } ld_state_e;

    localparam logic [1:0] ADDR_REF  = 2'b00;
    localparam logic [1:0] ADDR_FB   = 2'b01;
    localparam logic [1:0] ADDR_INIT = 2'b11;

endpackage

// File: rtl/spc_tick_gen.sv
module spc_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == CW'(DIV - 1));

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spc_sync.sv
module spc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
    import synth_prog_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int WORD_W  = 24,
    parameter int ADDR_W  = 2,
    parameter logic [WORD_W-ADDR_W-1:0] REF_PAYLOAD  = 22'h000028,
    parameter logic [WORD_W-ADDR_W-1:0] FB_PAYLOAD   = 22'h0103E8,
    parameter logic [WORD_W-ADDR_W-1:0] INIT_PAYLOAD = 22'h024092
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    output logic              req_ready,
    output logic              xfer_done,
    output logic              init_done,
    input  logic              chip_en_req,
    output logic              chip_en,
    input  logic              lock_in,
    output logic              locked,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le
);
    localparam int NUM_INIT = 3;
    localparam int IDX_W    = $clog2(NUM_INIT);
    localparam int BIT_W    = $clog2(WORD_W);

    localparam logic [WORD_W-1:0] INIT_WORDS [NUM_INIT] = '{
        {REF_PAYLOAD,  ADDR_REF},
        {FB_PAYLOAD,   ADDR_FB},
        {INIT_PAYLOAD, ADDR_INIT}
    };

    typedef struct packed {
        ld_state_e         st;
        logic [WORD_W-1:0] sh;
        logic [BIT_W-1:0]  bits;
        logic [IDX_W-1:0]  idx;
        logic              init_done;
        logic              sclk;
        logic              le;
        logic              done;
        logic              ce;
        logic              lock;
    } ld_regs_t;

    localparam ld_regs_t RESET_VAL = '{
        st: ST_IDLE, sh: '0, bits: '0, idx: '0, init_done: 1'b0,
        sclk: 1'b0, le: 1'b1, done: 1'b0, ce: 1'b0, lock: 1'b0
    };

    ld_regs_t r_d, r_q;
    logic     tick;
    logic     lock_sync;

    spc_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.st != ST_IDLE),
        .tick  (tick)
    );

    spc_sync #(.STAGES(2)) u_lock_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lock_in),
        .q     (lock_sync)
    );

    assign req_ready = (r_q.st == ST_IDLE) && r_q.init_done;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ce   = chip_en_req;
        r_d.lock = lock_sync && r_q.init_done;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!r_q.init_done) begin
                    r_d.st   = ST_LOW;
                    r_d.sh   = INIT_WORDS[r_q.idx];
                    r_d.bits = '0;
                    r_d.le   = 1'b0;
                end else if (req_valid) begin
                    r_d.st   = ST_LOW;
                    r_d.sh   = req_word;
                    r_d.bits = '0;
                    r_d.le   = 1'b0;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    r_d.sclk = 1'b1;
                    r_d.st   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    r_d.sclk = 1'b0;
                    if (r_q.bits == BIT_W'(WORD_W - 1)) begin
                        r_d.st = ST_COMMIT;
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                        r_d.sh   = {r_q.sh[WORD_W-2:0], 1'b0};
                        r_d.st   = ST_LOW;
                    end
                end
            end
            ST_COMMIT: begin
                if (tick) begin
                    r_d.le   = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                    if (!r_q.init_done) begin
                        if (r_q.idx == IDX_W'(NUM_INIT - 1)) r_d.init_done = 1'b1;
                        else                                 r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign xfer_done = r_q.done;
    assign init_done = r_q.init_done;
    assign chip_en   = r_q.ce;
    assign locked    = r_q.lock;
    assign ser_clk   = r_q.sclk;
    assign ser_le    = r_q.le;
    assign ser_data  = r_q.sh[WORD_W-1];

endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic xfer_done,
    input logic init_done,
    input logic locked,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_le
);
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> !ser_clk);

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_data));

    p_ready_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);

    p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_done_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $rose(ser_le));

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!ser_le && !req_ready));

    p_lock_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> init_done);
endmodule

bind synth_prog_ctrl synth_prog_chk u_chk (.*);

// File: tb/synth_prog_ctrl_bench.sv
module synth_prog_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam logic [21:0] P_REF  = 22'h012345;
    localparam logic [21:0] P_FB   = 22'h2ABCDE;
    localparam logic [21:0] P_INIT = 22'h3F00F1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [23:0] req_word;
    logic        req_ready, xfer_done, init_done;
    logic        chip_en_req, chip_en;
    logic        lock_in, locked;
    logic        ser_clk, ser_data, ser_le;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    synth_prog_ctrl #(
        .CLK_DIV(DIV), .WORD_W(24), .ADDR_W(2),
        .REF_PAYLOAD(P_REF), .FB_PAYLOAD(P_FB), .INIT_PAYLOAD(P_INIT)
    ) u_synth_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_ready(req_ready), .xfer_done(xfer_done), .init_done(init_done),
        .chip_en_req(chip_en_req), .chip_en(chip_en), .lock_in(lock_in),
        .locked(locked), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le)
    );

    // Behavioural serial receiver
    logic [23:0] rx_sh = '0;
    logic [23:0] rx_words [0:31];
    int rx_bits = 0;
    int rx_cnt = 0;
    int frame_err = 0;
    bit in_frame = 0;

    always @(negedge ser_le) begin
        rx_bits  = 0;
        in_frame = 1;
    end
    always @(posedge ser_clk) begin
        if (ser_le !== 1'b0) frame_err++;
        else begin
            rx_sh = {rx_sh[22:0], ser_data};
            rx_bits++;
        end
    end
    always @(posedge ser_le) begin
        if (in_frame) begin
            if (rx_bits != 24) frame_err++;
            if (rx_cnt < 32) rx_words[rx_cnt] = rx_sh;
            rx_cnt++;
            in_frame = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_init(input int i);
        case (i)
            0:       return {P_REF,  2'b00};
            1:       return {P_FB,   2'b01};
            default: return {P_INIT, 2'b11};
        endcase
    endfunction

    task automatic send(input logic [23:0] w, input int gap);
        int base;
        int lat;
        int exp_cnt;
        bit bad_ready;
        repeat (gap) @(negedge clk);
        req_valid = 1'b1;
        req_word  = w;
        while (!req_ready) @(negedge clk);
        base    = cyc;
        exp_cnt = rx_cnt + 1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R7", "ready after accept", 32'(req_ready), 32'd0);
        req_word  = ~w;
        bad_ready = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (req_ready) bad_ready = 1;
        end
        req_valid = 1'b0;
        chk(!bad_ready, "R7", "ready while busy", 32'(bad_ready), 32'd0);
        chip_en_req = ~chip_en_req;
        @(negedge clk);
        chk(chip_en == chip_en_req, "R8", "chip_en mid-transfer", 32'(chip_en), 32'(chip_en_req));
        while (!xfer_done) @(negedge clk);
        lat = cyc - base;
        chk(lat == 49*DIV + 1, "R6", "done latency", 32'(lat), 32'(49*DIV + 1));
        chk(rx_cnt == exp_cnt, "R7", "word count", 32'(rx_cnt), 32'(exp_cnt));
        chk(rx_words[exp_cnt-1] == w, "R5", "word value", 32'(rx_words[exp_cnt-1]), 32'(w));
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        bit early_ready;
        int guard;
        bit lk;
        void'($urandom(32'd4711));
        rst_n = 1'b0; req_valid = 1'b0; req_word = '0;
        chip_en_req = 1'b0; lock_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ser_le == 1'b1,   "R1", "le in reset",   32'(ser_le), 32'd1);
        chk(ser_clk == 1'b0 && ser_data == 1'b0, "R1", "sclk/data in reset",
            32'({ser_clk, ser_data}), 32'd0);
        chk({req_ready, xfer_done, init_done, locked} == 4'b0, "R1", "status in reset",
            32'({req_ready, xfer_done, init_done, locked}), 32'd0);
        lock_in = 1'b1;
        rst_n = 1'b1;
        // R3: ready held low through start-up; R9: locked gated
        early_ready = 0;
        guard = 0;
        lk = 0;
        while (!init_done && guard < 5000) begin
            @(negedge clk);
            if (req_ready && !init_done) early_ready = 1;
            if (locked && !init_done) lk = 1;
            guard++;
        end
        chk(!early_ready, "R3", "ready before init", 32'(early_ready), 32'd0);
        chk(!lk, "R9", "locked before init", 32'(lk), 32'd0);
        chk(xfer_done == 1'b1, "R3", "init_done with third done", 32'(xfer_done), 32'd1);
        chk(rx_cnt == 3, "R2", "startup word count", 32'(rx_cnt), 32'd3);
        for (int i = 0; i < 3; i++) begin
            chk(rx_words[i] == exp_init(i), "R2", "startup word", 32'(rx_words[i]), 32'(exp_init(i)));
            chk(rx_words[i][1:0] == exp_init(i)[1:0], "R2", "address bits",
                32'(rx_words[i][1:0]), 32'(exp_init(i)[1:0]));
        end
        // R9 lock latency after init
        @(negedge clk);
        chk(locked == 1'b1, "R9", "locked after init", 32'(locked), 32'd1);
        lock_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(locked == 1'b1, "R9", "locked after 2 cycles", 32'(locked), 32'd1);
        @(negedge clk);
        chk(locked == 1'b0, "R9", "locked after 3 cycles", 32'(locked), 32'd0);
        // R8 while idle
        chip_en_req = 1'b1;
        @(negedge clk);
        chk(chip_en == 1'b1, "R8", "chip_en idle", 32'(chip_en), 32'd1);
        // Directed words R4 R5 R6 R7
        send(24'hFFFFFF, 0);
        send(24'h000000, 0);
        send(24'h800001, 3);
        send(24'h555555, 1);
        // Random words
        for (int i = 0; i < 10; i++) begin
            send(24'($urandom()), int'($urandom_range(5, 0)));
            lock_in = 1'($urandom());
        end
        repeat (4) @(negedge clk);
        chk(locked == lock_in, "R9", "locked follows random lock", 32'(locked), 32'(lock_in));
        chk(init_done == 1'b1, "R3", "init_done sticky", 32'(init_done), 32'd1);
        chk(frame_err == 0, "R4", "framing errors", 32'(frame_err), 32'd0);
        chk(ser_le == 1'b1 && ser_clk == 1'b0, "R4", "idle lines",
            32'({ser_le, ser_clk}), 32'b10);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule